// File: doc/BRIEF.md
# Flag-Handshaked Character I/O Port

This block couples a slow character terminal to a simple accumulator processor. It has two one-character holding registers, one for each direction. Each direction has a ready flag that tells the processor when it may act. The input flag rises when the terminal delivers a character. It falls when the processor reads that character into the accumulator. The output flag is high while the output register is free. It falls when the processor writes a character. It rises again once the terminal reports that it has finished with that character.

On the processor side the block decodes a 12-bit operand field of an I/O instruction. Six field bits each select one operation: read a character, write a character, skip on the input flag, skip on the output flag, enable interrupts, and disable interrupts. An operation acts only when the three qualifiers (major-opcode-7 decode, indirect bit and execute slot) are all high. The block returns an accumulator write strobe with its data and a skip request for the program counter. It also raises an interrupt request while interrupts are enabled and either flag is high.

The terminal side uses valid/ready.
- Input: `in_ready` is the input flag inverted. A character offered while `in_ready` is low is not held off. It is dropped and counted.
- Output: `out_valid` stays high, with `out_data` stable, until `out_ready` is seen. After that the terminal pulses `out_done` once the character has been printed.

Top module: `chario_port`

## Requirements
- R1: After reset `in_ready`=1 (input flag 0), `out_free`=1 (output flag 1), `out_valid`=0, `out_data`=0, `irq_req`=0 and `ovr_count`=0.
- R2: When `in_valid` is high while `in_ready` is high, the character is stored and `in_ready` is low from the next cycle on.
- R3: When `in_valid` is high while `in_ready` is low, the character is dropped and the stored character is kept. `ovr_count` rises by one and stops at its maximum value.
- R4: A field bit has no effect unless `op_d7`, `op_ind` and `op_t3` are all 1 in that cycle.
- R5: Field bit 11 (read character) raises `ac_we` in the same cycle, with `ac_wdata` equal to the stored input character, and sets the input flag to 0 at the clock edge. When `ac_we` is 0, `ac_wdata` is 0.
- R6: Field bit 10 (write character) with `out_free`=1 loads `ac_low` into the output register and clears the output flag. `out_valid` then rises with that data. With `out_free`=0 the bit is ignored and `out_data` is kept.
- R7: `out_valid` stays high until `out_ready` is seen. An `out_done` pulse sets `out_free` only after that acceptance. An `out_done` while `out_valid` is high is ignored.
- R8: Field bit 9 raises `skip_req` in the same cycle when the input flag is 1.
- R9: Field bit 8 raises `skip_req` in the same cycle when the output flag is 1.
- R10: Field bit 7 enables interrupts and field bit 6 disables them. When both bits are set, the disable wins.
- R11: `irq_req` is high exactly when interrupts are enabled and the input flag or the output flag is 1.
- R12: Field bits 5..0 have no effect. Several of bits 11..6 may be combined, and each one acts on the flag values from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Terminal offers a character |
| in_data | input | CHAR_W | Offered character |
| in_ready | output | 1 | Input register free (input flag inverted) |
| out_valid | output | 1 | Output character waiting for the terminal |
| out_data | output | CHAR_W | Output register |
| out_ready | input | 1 | Terminal takes the output character |
| out_done | input | 1 | Terminal has finished printing |
| out_free | output | 1 | Output flag |
| op_d7 | input | 1 | Major opcode 7 decoded |
| op_ind | input | 1 | Indirect bit of the instruction |
| op_t3 | input | 1 | Execute timing slot |
| op_field | input | FIELD_W | Instruction operand field |
| ac_low | input | CHAR_W | Low byte of the accumulator |
| ac_we | output | 1 | Write the accumulator low byte |
| ac_wdata | output | CHAR_W | Data for the accumulator |
| skip_req | output | 1 | Request a program counter increment |
| irq_req | output | 1 | Interrupt request |
| ovr_count | output | OVR_W | Saturating count of dropped input characters |

## Verification
The hardest state to reach is a single instruction that combines a read, a write and a skip-on-input while the input flag is set. Here the skip must use the flag value from before the read clears it. A character must be accepted first, and the write must find the output flag free. The vector table therefore delivers a fresh character and then issues the combined field in the next entry. Saturating the overrun count needs a long run of strobes against a locked input register. A directed loop delivers one character and then offers twenty more without a read in between.

// File: rtl/cio_pkg.sv
package cio_pkg;
  // Positions of the operation-select bits inside the operand field
  localparam int BIT_RD  = 11;
  localparam int BIT_WR  = 10;
  localparam int BIT_SKI = 9;
  localparam int BIT_SKO = 8;
  localparam int BIT_EN  = 7;
  localparam int BIT_DIS = 6;

  typedef struct packed {
    logic rd;
    logic wr;
    logic sk_in;
    logic sk_out;
    logic irq_on;
    logic irq_off;
  } io_cmd_t;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import cio_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic               sel_d7,
  input  logic               sel_ind,
  input  logic               sel_t3,
  input  logic [FIELD_W-1:0] field,
  output io_cmd_t            cmd
);
  localparam int TOP_BIT = BIT_RD;
  logic qual;

  generate
    if (FIELD_W > TOP_BIT) begin : g_ok
      assign qual = sel_d7 & sel_ind & sel_t3;
    end else begin : g_narrow
      assign qual = 1'b0;
    end
  endgenerate

  always_comb begin
    cmd         = '0;
    cmd.rd      = qual & field[BIT_RD];
    cmd.wr      = qual & field[BIT_WR];
    cmd.sk_in   = qual & field[BIT_SKI];
    cmd.sk_out  = qual & field[BIT_SKO];
    cmd.irq_on  = qual & field[BIT_EN];
    cmd.irq_off = qual & field[BIT_DIS];
  end
endmodule

// File: rtl/cio_in_chan.sv
module cio_in_chan #(
  parameter int CHAR_W = 8,
  parameter int OVR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic [CHAR_W-1:0] dev_data,
  input  logic              take,
  output logic              flag,
  output logic [CHAR_W-1:0] data,
  output logic [OVR_W-1:0]  ovr_cnt
);
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};
  logic accept, drop;

  assign accept = dev_valid & ~flag;
  assign drop   = dev_valid & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      data    <= '0;
      ovr_cnt <= '0;
    end else begin
      if (accept) begin
        data <= dev_data;
        flag <= 1'b1;
      end else if (take) begin
        flag <= 1'b0;
      end
      if (drop && ovr_cnt != OVR_MAX) ovr_cnt <= ovr_cnt + 1'b1;
    end
  end

  AST_INPUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !take) |=> (data == $past(data))); // R3
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && flag && ovr_cnt != OVR_MAX) |=> (ovr_cnt == $past(ovr_cnt) + 1'b1)); // R3
  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !flag) |=> flag); // R2
endmodule

// File: rtl/cio_out_chan.sv
module cio_out_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [CHAR_W-1:0] ac_byte,
  input  logic              dev_ready,
  input  logic              dev_done,
  output logic              flag,
  output logic              valid,
  output logic [CHAR_W-1:0] data
);
  logic load;
  assign load = load_req & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b1;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (load) begin
        data  <= ac_byte;
        valid <= 1'b1;
        flag  <= 1'b0;
      end else begin
        if (valid && dev_ready) valid <= 1'b0;
        if (dev_done && !valid && !flag) flag <= 1'b1;
      end
    end
  end

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> $stable(data)); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dev_ready) |=> (valid && $stable(data))); // R7
  AST_DONE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !flag) |=> !flag); // R7
endmodule

// File: rtl/cio_irq.sv
module cio_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  input  logic fl_in,
  input  logic fl_out,
  output logic irq
);
  logic ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien <= 1'b0;
    else if (clr_en) ien <= 1'b0;
    else if (set_en) ien <= 1'b1;
  end

  assign irq = ien & (fl_in | fl_out);

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !irq); // R10
  AST_ENABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> (irq == (fl_in | fl_out))); // R11
endmodule

// File: rtl/chario_port.sv
module chario_port
  import cio_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int FIELD_W = 12,
  parameter int OVR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CHAR_W-1:0]  in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [CHAR_W-1:0]  out_data,
  input  logic               out_ready,
  input  logic               out_done,
  output logic               out_free,
  input  logic               op_d7,
  input  logic               op_ind,
  input  logic               op_t3,
  input  logic [FIELD_W-1:0] op_field,
  input  logic [CHAR_W-1:0]  ac_low,
  output logic               ac_we,
  output logic [CHAR_W-1:0]  ac_wdata,
  output logic               skip_req,
  output logic               irq_req,
  output logic [OVR_W-1:0]   ovr_count
);
  io_cmd_t           cmd;
  logic              fgi, fgo;
  logic [CHAR_W-1:0] in_char;

  cio_decode #(.FIELD_W(FIELD_W)) u_dec (
    .sel_d7(op_d7), .sel_ind(op_ind), .sel_t3(op_t3),
    .field(op_field), .cmd(cmd)
  );

  cio_in_chan #(.CHAR_W(CHAR_W), .OVR_W(OVR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .dev_valid(in_valid), .dev_data(in_data),
    .take(cmd.rd), .flag(fgi), .data(in_char), .ovr_cnt(ovr_count)
  );

  cio_out_chan #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_req(cmd.wr), .ac_byte(ac_low),
    .dev_ready(out_ready), .dev_done(out_done),
    .flag(fgo), .valid(out_valid), .data(out_data)
  );

  cio_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_en(cmd.irq_on), .clr_en(cmd.irq_off),
    .fl_in(fgi), .fl_out(fgo), .irq(irq_req)
  );

  assign in_ready = ~fgi;
  assign out_free = fgo;
  assign ac_we    = cmd.rd;
  assign ac_wdata = cmd.rd ? in_char : '0;
  assign skip_req = (cmd.sk_in & fgi) | (cmd.sk_out & fgo);

  AST_SKIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (op_d7 && op_ind && op_t3)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_we && !in_valid) |=> in_ready); // R5
  AST_LOW_BITS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_field[FIELD_W-1:6] == '0) |-> (!ac_we && !skip_req)); // R12
endmodule

// File: tb/sim_chario_port.sv
module sim_chario_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_free, ac_we, skip_req, irq_req;
  logic [7:0]  out_data, ac_wdata;
  logic        out_ready = 1'b0, out_done = 1'b0;
  logic        op_d7 = 1'b0, op_ind = 1'b0, op_t3 = 1'b0;
  logic [11:0] op_field = '0;
  logic [7:0]  ac_low = '0;
  logic [3:0]  ovr_count;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chario_port u0 (.*);

  // stim {iv,id,ex,fld,ac,ordy,odone} | exp {we,wd,sk,inr,ofree,oval,od,irq}
  localparam int NV = 17;
  localparam logic [53:0] VEC [NV] = '{
    {1'b1,8'h41,1'b0,12'h000,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0}, // R2
    {1'b0,8'h00,1'b1,12'h200,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0}, // R8
    {1'b0,8'h00,1'b1,12'h080,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b1}, // R10 R11
    {1'b1,8'h42,1'b0,12'h000,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b1}, // R3
    {1'b0,8'h00,1'b1,12'h800,8'h00,1'b0,1'b0, 1'b1,8'h41,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1}, // R5
    {1'b0,8'h00,1'b0,12'h400,8'h55,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1}, // R4
    {1'b0,8'h00,1'b1,12'h400,8'h55,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,8'h55,1'b0}, // R6 R11
    {1'b0,8'h00,1'b1,12'h100,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,8'h55,1'b0}, // R9
    {1'b0,8'h00,1'b1,12'h400,8'h66,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,8'h55,1'b0}, // R6
    {1'b0,8'h00,1'b0,12'h000,8'h00,1'b0,1'b1, 1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,8'h55,1'b0}, // R7
    {1'b0,8'h00,1'b0,12'h000,8'h00,1'b1,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h55,1'b0}, // R7
    {1'b0,8'h00,1'b0,12'h000,8'h00,1'b0,1'b1, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h55,1'b1}, // R7
    {1'b0,8'h00,1'b1,12'h140,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,8'h55,1'b0}, // R9 R10
    {1'b0,8'h00,1'b1,12'h0C0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h55,1'b0}, // R10
    {1'b0,8'h00,1'b1,12'h03F,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h55,1'b0}, // R12
    {1'b1,8'h5A,1'b0,12'h000,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h55,1'b0}, // R2
    {1'b0,8'h00,1'b1,12'hE00,8'h77,1'b0,1'b0, 1'b1,8'h5A,1'b1,1'b1,1'b0,1'b1,8'h77,1'b0}  // R12
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; op_d7 = 0; op_ind = 0; op_t3 = 0; op_field = '0;
    ac_low = '0; out_ready = 0; out_done = 0;
  endtask

  task automatic check_reset();
    check("R1 in_ready", in_ready, 1);
    check("R1 out_free", out_free, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_data", out_data, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 ovr_count", ovr_count, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      in_valid = v[53]; in_data = v[52:45];
      op_d7 = v[44]; op_ind = v[44]; op_t3 = v[44];
      op_field = v[43:32]; ac_low = v[31:24];
      out_ready = v[23]; out_done = v[22];
      #5;
      check($sformatf("vec%0d ac_we", i), ac_we, v[21]);
      check($sformatf("vec%0d ac_wdata", i), ac_wdata, v[20:13]);
      check($sformatf("vec%0d skip_req", i), skip_req, v[12]);
      @(posedge clk); #2;
      idle();
      check($sformatf("vec%0d in_ready", i), in_ready, v[11]);
      check($sformatf("vec%0d out_free", i), out_free, v[10]);
      check($sformatf("vec%0d out_valid", i), out_valid, v[9]);
      check($sformatf("vec%0d out_data", i), out_data, v[8:1]);
      check($sformatf("vec%0d irq_req", i), irq_req, v[0]);
      @(negedge clk);
    end

    check("R3 one drop counted", ovr_count, 1);

    // R4: a read with one qualifier missing must not act
    in_valid = 1; in_data = 8'h33;
    @(negedge clk);
    idle();
    for (int k = 0; k < 3; k++) begin
      op_d7 = (k != 0); op_ind = (k != 1); op_t3 = (k != 2);
      op_field = 12'h800;
      #5;
      check("R4 partial qualifier ac_we", ac_we, 0);
      @(posedge clk); #2;
      idle();
      check("R4 partial qualifier in_ready", in_ready, 0);
      @(negedge clk);
    end

    // R3: saturation of the drop count, stored char kept
    for (int k = 0; k < 20; k++) begin
      in_valid = 1; in_data = 8'(k);
      @(negedge clk);
    end
    idle();
    check("R3 saturated count", ovr_count, 15);
    op_d7 = 1; op_ind = 1; op_t3 = 1; op_field = 12'h800;
    #5;
    check("R3 kept char", ac_wdata, 8'h33);
    check("R5 ac_we", ac_we, 1);
    @(posedge clk); #2;
    idle();
    check("R5 flag cleared", in_ready, 1);

    // R1: reset in mid-run
    @(negedge clk);
    in_valid = 1; in_data = 8'h11;
    @(negedge clk);
    idle();
    rst_n = 0;
    #3;
    check_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule